// File: doc/BRIEF.md
# Invalid Instruction Form Detector

This block inspects one 32-bit instruction word each time a valid strobe is raised and reports whether the word belongs to one of the instruction forms it tracks. For those forms it also reports whether the register fields make the instruction architecturally invalid. The forms are: loads and stores that write the computed address back to the base register, load multiple word, load string immediate, floating-point register-pair accesses, quadword load and store, move to special register, and branch through the count register. Bits are numbered big-endian, so bit 0 of the architectural word is `in_word[31]`.

A front-end stage places the detector beside its decoder and uses the registered result to raise an illegal-instruction exception or to leave the instruction to the normal pipe. The detector does not execute anything. It only compares opcode fields and register fields. Words outside the tracked set are marked as unrecognized and are never flagged as illegal.

Top module: `ifd_top`

## Requirements
- R1: The result appears on the first rising edge after `in_valid` is sampled high, with `out_valid` high for that one cycle. In every cycle without a result, and after reset, `out_valid`, `out_known` and `out_illegal` are 0 and `out_class` is 0.
- R2: A word outside the tracked set gives `out_known`=0, `out_illegal`=0 and `out_class`=0. Opcode 58 with `in_word[1:0]`=00 and opcode 31 with extended code 266 are both outside the set. The primary opcode is `in_word[31:26]` and the extended opcode is `in_word[10:1]`.
- R3: Update loads (class 1) are illegal when the base field `in_word[20:16]` is 0 or equals the target field `in_word[25:21]`. These are opcodes 35, 41, 43 and 33, opcode 58 with `in_word[1:0]`=01, and opcode 31 with extended codes 119, 311, 375, 55, 373 and 53.
- R4: Base-only update forms (class 2) are illegal only when the base field is 0. A target field equal to the base is legal for this class. The class covers the integer stores 39, 45 and 37, opcode 62 with `in_word[1:0]`=01, the floating loads and stores 49, 51, 53 and 55, and opcode 31 with extended codes 247, 439, 183, 181, 567, 631, 695 and 759.
- R5: Load multiple word (opcode 46, class 3) is illegal when the base is 0 or when target <= base.
- R6: Load string immediate (opcode 31, extended code 597, class 4) takes n = NB from `in_word[15:11]`, with NB=0 meaning 32. Its registers run from the target field for ceil(n/4) registers and wrap modulo 32. The instruction is illegal when the base falls in that run, that is, when (base - target) mod 32 < ceil(n/4).
- R7: Pair forms (class 5) are illegal when the pair field `in_word[25:21]` is odd. The class covers opcode 57 or 61 with `in_word[1:0]`=00, opcode 31 with extended code 791 or 919, and opcode 62 with `in_word[1:0]`=10.
- R8: Quadword load (opcode 56, class 6) is illegal when the pair field is odd or equals the base field.
- R9: Move to special register (opcode 31, extended code 467, class 7) is illegal unless its register number is 1, 8, 9, 256, 512, 896 or 898. The register number is {`in_word[15:11]`, `in_word[20:16]`}.
- R10: Branch through count register (opcode 19, extended code 528, class 8) is illegal when BO bit 2 (`in_word[23]`) is 0.
- R11: `in_word[0]` has no effect on decoding of forms that use opcode 31 or 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: `in_word` holds an instruction this cycle |
| in_word | input | 32 | Instruction word, architectural bit 0 at index 31 |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_known | output | 1 | Word belongs to a tracked form |
| out_illegal | output | 1 | Tracked form with an invalid field combination |
| out_class | output | 4 | Form class code 0..8 |

## Verification
A wrong class from the decoder shows up as a wrong `out_class` in the cycle after the strobe. It also sends the word through the wrong rule, so a legal word can be flagged or an illegal word missed. The bench places words on both sides of each rule's boundary so that either fault is caught. A wrong field position or a wrong wrap in the string-range arithmetic changes only `out_illegal`, and only for boundary words. For that reason the bench drives the range edges of R6 and the edges of each equality rule. Output state held across an idle cycle is caught one cycle later, when `out_valid` is low but the other outputs are not zero.

// File: rtl/ifd_pkg.sv
// Package: shared widths, opcode constants, form classes and the decoded field record
// for the invalid instruction form detector.
package ifd_pkg;
    localparam int WORD_W = 32;
    localparam int OPC_W  = 6;
    localparam int REG_W  = 5;
    localparam int XO_W   = 10;
    localparam int SUB_W  = 2;
    localparam int SPR_W  = 2 * REG_W;
    localparam int CLS_W  = 4;

    // Big-endian bit b of the word sits at index WORD_W-1-b.
    localparam int OPC_LSB = WORD_W - OPC_W;
    localparam int RT_LSB  = OPC_LSB - REG_W;
    localparam int RA_LSB  = RT_LSB - REG_W;
    localparam int RB_LSB  = RA_LSB - REG_W;
    localparam int XO_LSB  = 1;
    localparam int BO2_IDX = RT_LSB + REG_W - 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE      = 4'd0,
        CLS_UPD_LOAD  = 4'd1,
        CLS_UPD_BASE  = 4'd2,
        CLS_LOAD_MULT = 4'd3,
        CLS_LOAD_STR  = 4'd4,
        CLS_PAIR      = 4'd5,
        CLS_QUAD_LOAD = 4'd6,
        CLS_SPR_MOVE  = 4'd7,
        CLS_BR_CTR    = 4'd8
    } form_cls_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] ra;
        logic [REG_W-1:0] rb;
        logic [XO_W-1:0]  xo;
        logic [SUB_W-1:0] sub;
        logic             bo2;
    } fields_t;
endpackage

// File: rtl/ifd_field_split.sv
// Module: ifd_field_split
// Cuts the instruction word into its opcode, register and sub-code fields.
// Assumes big-endian numbering: architectural bit 0 is the MSB of the word.
module ifd_field_split
    import ifd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fields_t           fld
);
    // Purpose: pure wiring of the word fields into the record.
    always_comb begin
        fld.opc = word[OPC_LSB +: OPC_W];
        fld.rt  = word[RT_LSB  +: REG_W];
        fld.ra  = word[RA_LSB  +: REG_W];
        fld.rb  = word[RB_LSB  +: REG_W];
        fld.xo  = word[XO_LSB  +: XO_W];
        fld.sub = word[SUB_W-1:0];
        fld.bo2 = word[BO2_IDX];
    end
endmodule

// File: rtl/ifd_class_decode.sv
// Module: ifd_class_decode
// Maps the primary opcode, extended opcode and DS sub-code onto a form class.
// Assumes the extended opcode excludes the last bit of the word, so that bit is ignored.
module ifd_class_decode
    import ifd_pkg::*;
(
    input  fields_t   fld,
    output form_cls_e cls,
    output logic      known
);
    // Purpose: match opcode 31 extended codes onto a class.
    function automatic form_cls_e xo31(input logic [XO_W-1:0] xo);
        case (xo)
            10'd119, 10'd311, 10'd375, 10'd55, 10'd373, 10'd53:
                return CLS_UPD_LOAD;
            10'd247, 10'd439, 10'd183, 10'd181, 10'd567, 10'd631, 10'd695, 10'd759:
                return CLS_UPD_BASE;
            10'd597:          return CLS_LOAD_STR;
            10'd791, 10'd919: return CLS_PAIR;
            10'd467:          return CLS_SPR_MOVE;
            default:          return CLS_NONE;
        endcase
    endfunction

    // Purpose: primary opcode decode, with sub-code checks for the DS forms.
    always_comb begin
        case (fld.opc)
            6'd35, 6'd41, 6'd43, 6'd33:         cls = CLS_UPD_LOAD;
            6'd39, 6'd45, 6'd37,
            6'd49, 6'd51, 6'd53, 6'd55:         cls = CLS_UPD_BASE;
            6'd46:                              cls = CLS_LOAD_MULT;
            6'd56:                              cls = CLS_QUAD_LOAD;
            6'd58: cls = (fld.sub == 2'b01) ? CLS_UPD_LOAD : CLS_NONE;
            6'd57, 6'd61: cls = (fld.sub == 2'b00) ? CLS_PAIR : CLS_NONE;
            6'd62: cls = (fld.sub == 2'b01) ? CLS_UPD_BASE :
                         (fld.sub == 2'b10) ? CLS_PAIR : CLS_NONE;
            6'd31: cls = xo31(fld.xo);
            6'd19: cls = (fld.xo == 10'd528) ? CLS_BR_CTR : CLS_NONE;
            default:                            cls = CLS_NONE;
        endcase
        known = (cls != CLS_NONE);
    end
endmodule

// File: rtl/ifd_rule_check.sv
// Module: ifd_rule_check
// Applies the register-field rule of the given class and raises illegal.
// Assumes cls comes from ifd_class_decode. A class of NONE is never illegal.
module ifd_rule_check
    import ifd_pkg::*;
#(
    parameter int                     NUM_SPR  = 7,
    parameter logic [NUM_SPR*SPR_W-1:0] SPR_LIST = {10'd898, 10'd896, 10'd512,
                                                  10'd256, 10'd9, 10'd8, 10'd1}
)(
    input  form_cls_e cls,
    input  fields_t   fld,
    output logic      illegal
);
    localparam int CNT_W = REG_W + 1;

    logic [SPR_W-1:0]   spr_num;
    logic [NUM_SPR-1:0] spr_hit;
    logic [CNT_W-1:0]   str_bytes;
    logic [CNT_W-1:0]   str_regs;
    logic [REG_W-1:0]   str_off;
    logic               base_zero;

    assign spr_num = {fld.rb, fld.ra};

    // One comparator per allowed special register number.
    for (genvar g = 0; g < NUM_SPR; g++) begin : g_spr
        assign spr_hit[g] = (spr_num == SPR_LIST[g*SPR_W +: SPR_W]);
    end

    // Purpose: byte count, register count and wrapped offset of the base for the string load.
    always_comb begin
        str_bytes = (fld.rb == '0) ? CNT_W'(32) : {1'b0, fld.rb};
        str_regs  = (str_bytes + CNT_W'(3)) >> 2;
        str_off   = fld.ra - fld.rt;
        base_zero = (fld.ra == '0);
    end

    // Purpose: select the rule for the class.
    always_comb begin
        case (cls)
            CLS_UPD_LOAD:  illegal = base_zero || (fld.ra == fld.rt);
            CLS_UPD_BASE:  illegal = base_zero;
            CLS_LOAD_MULT: illegal = base_zero || (fld.rt <= fld.ra);
            CLS_LOAD_STR:  illegal = ({1'b0, str_off} < str_regs);
            CLS_PAIR:      illegal = fld.rt[0];
            CLS_QUAD_LOAD: illegal = fld.rt[0] || (fld.rt == fld.ra);
            CLS_SPR_MOVE:  illegal = ~|spr_hit;
            CLS_BR_CTR:    illegal = ~fld.bo2;
            default:       illegal = 1'b0;
        endcase
    end
endmodule

// File: rtl/ifd_top.sv
// Module: ifd_top
// Invalid instruction form detector: it registers the class, recognized flag and illegal
// flag one cycle after the strobe. Outputs are zero in cycles without a result.
// Assumes a synchronous active-low reset.
module ifd_top
    import ifd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic              out_known,
    output logic              out_illegal,
    output logic [CLS_W-1:0]  out_class
);
    fields_t   fld;
    form_cls_e cls;
    logic      known;
    logic      illegal;

    ifd_field_split u_split (.word(in_word), .fld(fld));
    ifd_class_decode u_dec (.fld(fld), .cls(cls), .known(known));
    ifd_rule_check u_rule (.cls(cls), .fld(fld), .illegal(illegal));

    // Purpose: result register, cleared in cycles without a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid   <= 1'b0;
            out_known   <= 1'b0;
            out_illegal <= 1'b0;
            out_class   <= '0;
        end else begin
            out_valid   <= 1'b1;
            out_known   <= known;
            out_illegal <= illegal;
            out_class   <= cls;
        end
    end

    a_r1_result_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_known && !out_illegal && out_class == '0));
    a_r2_unknown_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> out_known);
    a_r4_store_base_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fld.opc == 6'd39 && fld.ra != '0) |=> !out_illegal);
    a_r5_lmw_base_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fld.opc == 6'd46 && fld.ra == '0) |=> out_illegal);
    a_r10_ctr_bo: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fld.opc == 6'd19 && fld.xo == 10'd528 && !fld.bo2)
        |=> (out_illegal && out_class == CLS_W'(8)));
endmodule

// File: tb/sim_ifd_top.sv
`timescale 1ns/1ps
module sim_ifd_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid, out_known, out_illegal;
    logic [3:0]  out_class;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic       known;
        logic       ill;
        logic [3:0] cls;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    ifd_top u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
                .out_valid(out_valid), .out_known(out_known),
                .out_illegal(out_illegal), .out_class(out_class));

    function automatic logic [31:0] mk_d(int op, int rt, int ra, int low);
        return {op[5:0], rt[4:0], ra[4:0], low[15:0]};
    endfunction
    function automatic logic [31:0] mk_x(int op, int rt, int ra, int rb, int xo, bit lo);
        return {op[5:0], rt[4:0], ra[4:0], rb[4:0], xo[9:0], lo};
    endfunction
    function automatic logic [31:0] mk_spr(int spr);
        return {6'd31, 5'd1, spr[4:0], spr[9:5], 10'd467, 1'b0};
    endfunction

    task automatic send(logic [31:0] w, logic k, logic il, int cls, string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        e.known = k; e.ill = il; e.cls = cls[3:0]; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle_check(string tag);
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = 32'hFFFF_FFFF;
        @(negedge clk);
        @(negedge clk);
        n_chk++;
        if (out_valid || out_known || out_illegal || out_class != 0) begin
            n_fail++;
            $display("FAIL %s idle: got v=%0b k=%0b i=%0b c=%0d expected all 0",
                     tag, out_valid, out_known, out_illegal, out_class);
        end
    endtask

    // Monitor: pops an expected item for each result and compares it.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_chk++;
            if (q.size() == 0) begin
                n_fail++;
                $display("FAIL R1 unexpected result: got valid=1 expected none");
            end else begin
                exp_t e;
                e = q.pop_front();
                if (out_known !== e.known || out_illegal !== e.ill || out_class !== e.cls) begin
                    n_fail++;
                    $display("FAIL %s: got k=%0b i=%0b c=%0d expected k=%0b i=%0b c=%0d",
                             e.tag, out_known, out_illegal, out_class, e.known, e.ill, e.cls);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid || out_known || out_illegal || out_class != 0) begin
            n_fail++;
            $display("FAIL R1 reset: got v=%0b k=%0b i=%0b c=%0d expected all 0",
                     out_valid, out_known, out_illegal, out_class);
        end
        rst_n = 1'b1;
        // R3 update loads
        send(mk_d(35, 3, 4, 16), 1, 0, 1, "R3 lbzu distinct");
        send(mk_d(35, 5, 5, 0),  1, 1, 1, "R3 lbzu base=target");
        send(mk_d(43, 7, 0, 4),  1, 1, 1, "R3 lhau base zero");
        send(mk_x(31, 3, 3, 1, 119, 0), 1, 1, 1, "R3 lbzux base=target");
        send(mk_x(31, 3, 7, 1, 119, 1), 1, 0, 1, "R11 low bit set lbzux");
        send(mk_d(58, 2, 2, 1), 1, 1, 1, "R3 ldu base=target");
        // R2 unrecognized
        send(mk_d(58, 2, 0, 0), 0, 0, 0, "R2 plain ld");
        send(32'h0000_0000,     0, 0, 0, "R2 opcode 0");
        send(mk_x(31, 0, 0, 0, 266, 0), 0, 0, 0, "R2 opcode31 266");
        idle_check("R1 gap");
        // R4 base-only updates
        send(mk_d(39, 4, 4, 8), 1, 0, 2, "R4 stbu base=source legal");
        send(mk_d(39, 4, 0, 8), 1, 1, 2, "R4 stbu base zero");
        send(mk_x(31, 2, 0, 3, 759, 0), 1, 1, 2, "R4 stfdux base zero");
        send(mk_d(51, 6, 6, 0), 1, 0, 2, "R4 lfdu base=target legal");
        send(mk_d(62, 6, 6, 1), 1, 0, 2, "R4 stdu legal");
        // R5 load multiple
        send(mk_d(46, 10, 10, 0), 1, 1, 3, "R5 lmw rt=ra");
        send(mk_d(46, 10, 9, 0),  1, 0, 3, "R5 lmw rt>ra");
        send(mk_d(46, 10, 0, 0),  1, 1, 3, "R5 lmw base zero");
        // R6 string load, wrapping range
        send(mk_x(31, 30, 1, 12, 597, 0), 1, 0, 4, "R6 wrap edge outside");
        send(mk_x(31, 30, 0, 12, 597, 0), 1, 1, 4, "R6 wrap inside");
        send(mk_x(31, 4, 11, 0, 597, 0),  1, 1, 4, "R6 nb0 last reg");
        send(mk_x(31, 4, 12, 0, 597, 0),  1, 0, 4, "R6 nb0 past end");
        send(mk_x(31, 4, 5, 4, 597, 0),   1, 0, 4, "R6 four bytes one reg");
        // R7 pairs
        send(mk_d(57, 3, 1, 0), 1, 1, 5, "R7 lfdp odd");
        send(mk_d(57, 4, 1, 0), 1, 0, 5, "R7 lfdp even");
        send(mk_d(62, 5, 1, 2), 1, 1, 5, "R7 stq odd");
        send(mk_x(31, 2, 1, 3, 791, 0), 1, 0, 5, "R7 lfdpx even");
        send(mk_x(31, 9, 1, 3, 919, 0), 1, 1, 5, "R7 stfdpx odd");
        // R8 quadword load
        send(mk_d(56, 4, 4, 0), 1, 1, 6, "R8 lq pair=base");
        send(mk_d(56, 4, 5, 0), 1, 0, 6, "R8 lq legal");
        send(mk_d(56, 7, 5, 0), 1, 1, 6, "R8 lq odd");
        idle_check("R1 gap two");
        // R9 special register moves
        send(mk_spr(9),   1, 0, 7, "R9 spr 9");
        send(mk_spr(898), 1, 0, 7, "R9 spr 898");
        send(mk_spr(897), 1, 1, 7, "R9 spr 897");
        send(mk_spr(256), 1, 0, 7, "R9 spr 256");
        send(mk_spr(10),  1, 1, 7, "R9 spr 10");
        // R10 branch through count register
        send({6'd19, 5'b00100, 5'd0, 5'd0, 10'd528, 1'b0}, 1, 0, 8, "R10 bo2 set");
        send({6'd19, 5'b11011, 5'd0, 5'd0, 10'd528, 1'b1}, 1, 1, 8, "R10 bo2 clear");
        idle_check("R1 end");
        n_chk++;
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R1 missing results: got %0d pending expected 0", q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule